// File: doc/BRIEF.md
# Configurable 16-bit Timer/Counter

This block is a 16-bit up-counter with three operating modes. As a timer it counts an instruction tick, which is the system clock divided by four. As a counter it counts rising edges of an external clock pin, either resynchronised to the system clock or taken straight from the prescaled pin. In every mode the count source first passes through a prescaler that divides by 1, 2, 4 or 8. A run enable gates counting. Rollover from all ones to zero sets a sticky overflow flag. A one-cycle event-clear pulse from a neighbouring compare unit zeroes the count.

Software reaches the count through an 8-bit bus with two byte addresses. Reading the low byte captures the high byte into a shadow register, so a later high-byte read returns a value that matches the low byte. A high-byte write is held in a buffer. It reaches the count only when the low byte is written, so both halves load on the same edge.

A small registered state machine turns the control inputs into the active count path. Its states are `ST_OFF` (run enable low), `ST_TIMER` (run high, internal source), `ST_SYNC` (run high, external source, synchroniser on) and `ST_ASYNC` (run high, external source, synchroniser bypassed). Every state can move to any other state on the next clock edge. The transitions are, in priority order: "stop" to `ST_OFF` whenever run is low; "select timer" to `ST_TIMER` when the source select is 0; "select synced" to `ST_SYNC` when the sync enable is 1; otherwise "select direct" to `ST_ASYNC`.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0 and the low-byte read returns 0x00.
- R2: In timer mode (source select 0) with divide select 0, the count rises by exactly one every 4 system clock cycles.
- R3: Divide select values 0, 1, 2 and 3 divide by 1, 2, 4 and 8. In timer mode the interval between increments is therefore 4, 8, 16 or 32 cycles.
- R4: In synchronised counter mode (source select 1, sync enable 1), n rising edges on the external pin add n for divide-by-1. For a divide ratio r of 2 or more they add floor((n - r/2)/r) + 1 when n >= r/2, and 0 otherwise. This counts from a freshly cleared prescaler.
- R5: In direct counter mode (source select 1, sync enable 0) edges are counted by the same rule as R4. With divide-by-1, an external rise between clock edges shows in the count after the first following edge. Synchronised mode shows it after the third edge.
- R6: With run enable low the count holds, whatever the ticks or external edges.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag. The flag stays set until the overflow-clear input is pulsed.
- R8: An event-clear pulse zeroes the count on the next clock edge.
- R9: A read of byte address 0 returns the low byte and latches the current high byte. A read of byte address 1 returns that latched byte, even after the count has moved on.
- R10: A write to byte address 1 changes only a buffer. A write to byte address 0 loads the count with {buffer, data} on that edge.
- R11: Any bus write clears the prescaler. With divide-by-8 in timer mode, no increment follows a write for at least 28 cycles, and one has occurred by 32 cycles.
- R12: A low-byte write wins over an increment or an event clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count input, counted on rising edges |
| run_en_i | input | 1 | Counting enable |
| src_sel_i | input | 1 | 0: instruction tick, 1: external input |
| sync_en_i | input | 1 | 1: synchronise external source, 0: use directly |
| div_sel_i | input | 2 | Prescale select: divide by 1, 2, 4, 8 |
| evt_clr_i | input | 1 | One-cycle clear from the compare unit |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe (latches high byte on low read) |
| bus_addr_i | input | 1 | Byte select: 0 low, 1 high |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data (combinational on address) |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench measures the exact spacing between increments for every divide ratio. A prescaler that decodes the wrong bit or is off by one cycle therefore shows up as a shifted edge. External edge counts are swept over all ratios in both counter modes and compared with the closed-form edge formula. A prescaler that starts in the wrong phase would give one count too many or too few. The bench times an external rise between clock edges to tell the two counter modes apart. A bypass that still passes through the synchroniser, or a synchroniser with a missing stage, lands the increment on the wrong edge. The last group of checks covers a write in the same cycle as an increment, a write at mid-prescale, a high-byte read after the count moves, and flag stickiness. A design with the wrong priority, no prescaler clear, an unbuffered high byte or a self-clearing flag would show a stray count or a torn 16-bit value.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_TIMER = 2'd1,
        ST_SYNC  = 2'd2,
        ST_ASYNC = 2'd3
    } path_st_t;
endpackage

// File: rtl/tmr16_modefsm.sv
module tmr16_modefsm
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic src_sel,
    input  logic sync_en,
    output logic use_int,
    output logic use_sync,
    output logic use_async
);
    path_st_t st_q, st_d;

    always_comb begin
        if (!run_en)       st_d = ST_OFF;
        else if (!src_sel) st_d = ST_TIMER;
        else if (sync_en)  st_d = ST_SYNC;
        else               st_d = ST_ASYNC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        use_int   = 1'b0;
        use_sync  = 1'b0;
        use_async = 1'b0;
        unique case (st_q)
            ST_OFF:   ;
            ST_TIMER: use_int   = 1'b1;
            ST_SYNC:  use_sync  = 1'b1;
            ST_ASYNC: use_async = 1'b1;
            default:  ;
        endcase
    end

    // R6: with run low the path is idle on the next edge
    assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !(use_int || use_sync || use_async));
    assert_one_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({use_int, use_sync, use_async}));
endmodule

// File: rtl/tmr16_clkpath.sv
module tmr16_clkpath #(
    parameter int TICK_DIV = 4,
    parameter int PSC_W    = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             psc_clr,
    input  logic             use_int,
    input  logic             use_sync,
    input  logic             use_async,
    output logic             inc
);
    localparam int QW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [QW-1:0]    qdiv;
    logic             tick;
    logic [PSC_W-1:0] psc_int, psc_ext, mask;
    logic             int_pulse, ext_div, ext_clr_q, ext_rst;
    logic [2:0]       sync_q;
    logic             direct_q, sync_edge, direct_edge;

    assign tick = (qdiv == QW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    qdiv <= '0;
        else if (tick) qdiv <= '0;
        else           qdiv <= qdiv + QW'(1);
    end

    always_comb begin
        for (int i = 0; i < PSC_W; i++)
            mask[i] = (i < int'(div_sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       psc_int <= '0;
        else if (psc_clr) psc_int <= '0;
        else if (tick)    psc_int <= psc_int + PSC_W'(1);
    end

    assign int_pulse = tick && ((psc_int & mask) == mask);

    // external prescaler lives in the pin's clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_clr_q <= 1'b0;
        else        ext_clr_q <= psc_clr;
    end

    assign ext_rst = ext_clr_q | ~rst_n;

    always_ff @(posedge ext_clk_i or posedge ext_rst) begin
        if (ext_rst) psc_ext <= '0;
        else         psc_ext <= psc_ext + PSC_W'(1);
    end

    always_comb begin
        ext_div = ext_clk_i;
        for (int i = 0; i < PSC_W; i++)
            if (int'(div_sel) == i + 1) ext_div = psc_ext[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            direct_q <= 1'b0;
        end else begin
            sync_q   <= {sync_q[1:0], ext_div};
            direct_q <= ext_div;
        end
    end

    assign sync_edge   = sync_q[1] & ~sync_q[2];
    assign direct_edge = ext_div & ~direct_q;

    assign inc = (use_int & int_pulse) | (use_sync & sync_edge) | (use_async & direct_edge);

    // R2: an increment never lasts two cycles
    assert_single_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> !inc);
    // R11: a cleared prescaler cannot emit a timer pulse on the next edge unless dividing by 1
    assert_psc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_clr && div_sel != '0 && $stable(div_sel)) |=> !int_pulse);
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               evt_clr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               addr,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic               ovf_clr,
    output logic [CNT_W/2-1:0] rdata,
    output logic               ovf
);
    localparam int BUS_W = CNT_W / 2;

    logic [CNT_W-1:0] cnt;
    logic [BUS_W-1:0] hi_buf, hi_shadow;
    logic             wr_lo, wr_hi, roll;

    assign wr_lo = wr_en && !addr;
    assign wr_hi = wr_en && addr;
    assign roll  = inc && (cnt == '1) && !wr_lo && !evt_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            hi_buf    <= '0;
            hi_shadow <= '0;
            ovf       <= 1'b0;
        end else begin
            if (wr_lo)        cnt <= {hi_buf, wdata};
            else if (evt_clr) cnt <= '0;
            else if (inc)     cnt <= cnt + CNT_W'(1);
            if (wr_hi) hi_buf <= wdata;
            if (rd_en && !addr) hi_shadow <= cnt[CNT_W-1:BUS_W];
            if (roll)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assign rdata = addr ? hi_shadow : cnt[BUS_W-1:0];

    assert_low_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt[BUS_W-1:0] == $past(wdata));
    assert_evt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !wr_lo) |=> cnt == '0);
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !evt_clr) |=> $stable(cnt));
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit #(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 4,
    parameter int PSC_W    = 3,
    parameter int SEL_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_clk_i,
    input  logic               run_en_i,
    input  logic               src_sel_i,
    input  logic               sync_en_i,
    input  logic [SEL_W-1:0]   div_sel_i,
    input  logic               evt_clr_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic               bus_addr_i,
    input  logic [CNT_W/2-1:0] bus_wdata_i,
    output logic [CNT_W/2-1:0] bus_rdata_o,
    input  logic               ovf_clr_i,
    output logic               ovf_o
);
    logic use_int, use_sync, use_async, inc;

    tmr16_modefsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en_i),
        .src_sel   (src_sel_i),
        .sync_en   (sync_en_i),
        .use_int   (use_int),
        .use_sync  (use_sync),
        .use_async (use_async)
    );

    tmr16_clkpath #(.TICK_DIV(TICK_DIV), .PSC_W(PSC_W), .SEL_W(SEL_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk_i),
        .div_sel   (div_sel_i),
        .psc_clr   (bus_wr_i),
        .use_int   (use_int),
        .use_sync  (use_sync),
        .use_async (use_async),
        .inc       (inc)
    );

    tmr16_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .evt_clr (evt_clr_i),
        .wr_en   (bus_wr_i),
        .rd_en   (bus_rd_i),
        .addr    (bus_addr_i),
        .wdata   (bus_wdata_i),
        .ovf_clr (ovf_clr_i),
        .rdata   (bus_rdata_o),
        .ovf     (ovf_o)
    );
endmodule

// File: tb/test_tmr16_unit.sv
module test_tmr16_unit;
    localparam int CLK_P = 10;

    logic       clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
    logic       run_en = 0, src_sel = 0, sync_en = 0, evt_clr = 0;
    logic [1:0] div_sel = 0;
    logic       bus_wr = 0, bus_rd = 0, bus_addr = 0, ovf_clr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       ovf;
    int         vecs = 0, fails = 0;
    bit         done = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr16_unit i_tmr16_unit (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .run_en_i(run_en),
        .src_sel_i(src_sel), .sync_en_i(sync_en), .div_sel_i(div_sel),
        .evt_clr_i(evt_clr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .ovf_clr_i(ovf_clr), .ovf_o(ovf)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #(CLK_P/2);
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write16(input logic [15:0] v);
        bus_addr = 1; bus_wdata = v[15:8]; bus_wr = 1; step();
        bus_addr = 0; bus_wdata = v[7:0];  step();
        bus_wr = 0;
    endtask

    task automatic read16(output logic [15:0] v);
        bus_addr = 0; bus_rd = 1; #1 v[7:0] = bus_rdata;
        step();
        bus_rd = 0; bus_addr = 1; #1 v[15:8] = bus_rdata;
        bus_addr = 0;
    endtask

    task automatic ext_pulse();
        ext_clk = 1; step(5);
        ext_clk = 0; step(5);
    endtask

    task automatic wait_change();
        logic [7:0] p;
        p = bus_rdata;
        for (int k = 0; k < 300 && bus_rdata == p; k++) step();
    endtask

    function automatic int ext_expect(input int n, input int d);
        int r;
        r = 1 << d;
        if (d == 0) return n;
        if (n < r / 2) return 0;
        return (n - r / 2) / r + 1;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  p;
        step(3);
        rst_n = 1;
        step(2);

        // R1 reset state
        chk("R1 low byte", {8'h0, bus_rdata}, 16'h0000);
        read16(v);
        chk("R1 count", v, 16'h0000);
        chk("R1 ovf", {15'h0, ovf}, 16'h0);

        // R2 / R3 timer interval for every ratio
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d); src_sel = 0; run_en = 1;
            write16(16'h0000);
            step(2);
            wait_change();
            p = bus_rdata;
            step((4 << d) - 1);
            chk(d == 0 ? "R2 hold in interval" : "R3 hold in interval", {8'h0, bus_rdata}, {8'h0, p});
            step();
            chk(d == 0 ? "R2 increment" : "R3 increment", {8'h0, bus_rdata}, {8'h0, p + 8'd1});
        end

        // R6 hold while off, ticks and external edges ignored
        run_en = 0; step(3);
        p = bus_rdata;
        step(40);
        src_sel = 1; sync_en = 0; div_sel = 0;
        for (int k = 0; k < 4; k++) ext_pulse();
        chk("R6 hold when off", {8'h0, bus_rdata}, {8'h0, p});

        // R4 / R5 external edge counting over all ratios and both modes
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 4; d++) begin
                src_sel = 1; sync_en = (m == 0); div_sel = 2'(d); run_en = 1;
                step(2);
                write16(16'h0000);
                step(4);
                for (int k = 0; k < 11; k++) ext_pulse();
                step(5);
                read16(v);
                chk(m == 0 ? "R4 synced edge count" : "R5 direct edge count", v, 16'(ext_expect(11, d)));
            end
        end

        // R5 latency: direct mode after first edge, synced mode after third
        src_sel = 1; div_sel = 0; run_en = 1; sync_en = 0; step(2);
        write16(16'h0000); step(3);
        ext_clk = 1; step();
        chk("R5 direct latency", {8'h0, bus_rdata}, 16'h0001);
        ext_clk = 0; step(4);
        sync_en = 1; step(2);
        write16(16'h0000); step(3);
        ext_clk = 1; step();
        chk("R5 synced edge1", {8'h0, bus_rdata}, 16'h0000);
        step();
        chk("R5 synced edge2", {8'h0, bus_rdata}, 16'h0000);
        step();
        chk("R5 synced edge3", {8'h0, bus_rdata}, 16'h0001);
        ext_clk = 0; step(4);

        // R7 rollover and sticky flag
        src_sel = 0; div_sel = 0; run_en = 1; step(2);
        write16(16'hFFFE);
        chk("R7 no flag before rollover", {15'h0, ovf}, 16'h0);
        for (int k = 0; k < 40 && !ovf; k++) step();
        chk("R7 flag set", {15'h0, ovf}, 16'h1);
        chk("R7 wrapped to zero", {8'h0, bus_rdata}, 16'h0000);
        run_en = 0; step(10);
        chk("R7 flag sticky", {15'h0, ovf}, 16'h1);
        ovf_clr = 1; step(); ovf_clr = 0;
        chk("R7 flag cleared", {15'h0, ovf}, 16'h0);

        // R8 event clear
        write16(16'h1234);
        evt_clr = 1; step(); evt_clr = 0;
        read16(v);
        chk("R8 event clear", v, 16'h0000);

        // R12 write beats event clear
        bus_addr = 1; bus_wdata = 8'h5A; bus_wr = 1; step();
        bus_addr = 0; bus_wdata = 8'hA5; evt_clr = 1; step();
        bus_wr = 0; evt_clr = 0;
        read16(v);
        chk("R12 write over clear", v, 16'h5AA5);

        // R9 shadowed high byte
        write16(16'h12FE);
        src_sel = 0; div_sel = 0; run_en = 1; step(2);
        bus_addr = 0; bus_rd = 1; step(); bus_rd = 0;
        step(30);
        run_en = 0; step(2);
        bus_addr = 1; #1;
        chk("R9 shadow stays", {8'h0, bus_rdata}, 16'h0012);
        bus_addr = 0;
        read16(v);
        chk("R9 fresh high", {8'h0, v[15:8]}, 16'h0013);

        // R10 buffered high write
        write16(16'h0000);
        bus_addr = 1; bus_wdata = 8'hAB; bus_wr = 1; step(); bus_wr = 0; bus_addr = 0;
        read16(v);
        chk("R10 high buffered", v, 16'h0000);
        bus_addr = 0; bus_wdata = 8'hCD; bus_wr = 1; step(); bus_wr = 0;
        read16(v);
        chk("R10 both halves load", v, 16'hABCD);

        // R11 prescaler cleared by a write mid-prescale
        write16(16'h0000);
        src_sel = 0; div_sel = 3; run_en = 1; step(2);
        wait_change();
        step(12);
        bus_addr = 0; bus_wdata = 8'h50; bus_wr = 1; step(); bus_wr = 0;
        step(28);
        chk("R11 no early increment", {8'h0, bus_rdata}, 16'h0050);
        step(4);
        chk("R11 increment after full divide", {8'h0, bus_rdata}, 16'h0051);

        // R12 write beats an increment in the same cycle
        div_sel = 0; step(2);
        write16(16'h0040);
        wait_change();
        step(3);
        bus_addr = 0; bus_wdata = 8'h77; bus_wr = 1; step(); bus_wr = 0;
        chk("R12 write over increment", {8'h0, bus_rdata}, 16'h0077);
        step(4);
        chk("R12 counting resumes", {8'h0, bus_rdata}, 16'h0078);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule